// File: doc/BRIEF.md
# Linear-Phase Symmetric FIR Filter

This block is an even-length FIR filter whose impulse response is mirror-symmetric, h(n) = h(M-1-n), or mirror-antisymmetric, h(n) = -h(M-1-n). It accepts one signed sample on any clock where the input valid is high. It keeps the most recent M samples, where the newest sample is the one currently on the input and M-1 of them sit in registers. Each pair of samples that share a coefficient is first combined in a pre-adder, so the datapath needs only M/2 multipliers. The pre-adders add the pair in symmetric mode and subtract the mirrored sample in antisymmetric mode.

The M/2 unique coefficients are compile-time parameters in signed fixed point. The result leaves the block at full precision: input width + 1 pre-adder growth bit + coefficient width + clog2(M/2) accumulation bits. Requantization is left to the block downstream. The output is registered once, and a new result appears on the clock edge that captures the input sample.

Top module: `lin_phase_fir`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, the output valid and output data become 0 and every delay register is cleared. Samples sent after reset therefore see zero history.
- R2: The output valid is high in the cycle after each edge where the input valid was high, and low in the cycle after each edge where it was low.
- R3: In symmetric mode, the result registered with sample x[n] is the sum over i = 0..M-1 of h(i)*x[n-i], with h(i) = h(M-1-i).
- R4: In antisymmetric mode, the same convolution holds with h(i) = -h(M-1-i) for i >= M/2.
- R5: The delay line advances only on edges where the input valid is high. A stream with idle gaps gives the same results as the same samples sent back to back.
- R6: On edges where the input valid is low, the output data keeps its previous value.
- R7: The result is exact (no wraparound) for every input and coefficient value, including all inputs at the most negative value and extreme alternating inputs. The result width is DATA_W + 1 + COEF_W + clog2(TAPS/2).
- R8: The unique coefficient h(k), for k = 0..TAPS/2-1, is read from bits [k*COEF_W +: COEF_W] of the coefficient parameter as a signed two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | OUT_W | Signed full-precision filter result |

## Verification
The valid-timing and delay-line assertions assume that in_valid is low while reset is held. They also assume that in_valid and in_data change only away from the rising edge. The bench drives both inputs on falling edges and keeps in_valid low through every reset pulse. Each result is compared against a direct-form convolution over a history kept in the bench. The bench tests symmetric and antisymmetric copies of the filter side by side, using impulse, step, gapped, random and extreme-value streams.

// File: rtl/fir_pkg.sv
// Shared types and width helpers for the linear-phase FIR.
// Assumes an even tap count; widths are derived at elaboration time.
package fir_pkg;
    typedef enum logic {
        SYMMETRIC     = 1'b0,
        ANTISYMMETRIC = 1'b1
    } fir_sym_e;

    // Full-precision result width: pre-add growth bit plus tree growth.
    function automatic int fir_out_width(input int dw, input int cw, input int taps);
        return dw + 1 + cw + $clog2(taps / 2);
    endfunction
endpackage

// File: rtl/fir_delay_line.sv
// Sample history for the FIR. Slot 0 is the live input; slots 1..TAPS-1
// are registers that shift by one on every accepted sample.
// Assumes in_valid is qualified by the caller; reset is synchronous active-low.
module fir_delay_line #(
    parameter int TAPS   = 8,
    parameter int DATA_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_data,
    output logic [TAPS-1:0][DATA_W-1:0]  taps_o
);
    logic [TAPS-1:1][DATA_W-1:0] hist_q;

    // Shift history on accepted samples, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (in_valid) begin
            hist_q[1] <= in_data;
            for (int i = 2; i < TAPS; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // Expose live input plus registered history.
    always_comb begin
        taps_o[0] = in_data;
        for (int i = 1; i < TAPS; i++) taps_o[i] = hist_q[i];
    end

    assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> (hist_q[1] == $past(in_data)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(hist_q));
endmodule

// File: rtl/fir_preadd.sv
// Mirrored-tap pre-adders: pair k combines tap k with tap TAPS-1-k,
// adding in symmetric mode and subtracting in antisymmetric mode.
// One growth bit keeps the pair sum exact for extreme samples.
module fir_preadd #(
    parameter int               TAPS   = 8,
    parameter int               DATA_W = 12,
    parameter fir_pkg::fir_sym_e MODE  = fir_pkg::SYMMETRIC,
    localparam int              HALF   = TAPS / 2
) (
    input  logic [TAPS-1:0][DATA_W-1:0] taps_i,
    output logic [HALF-1:0][DATA_W:0]   pair_o
);
    for (genvar k = 0; k < HALF; k++) begin : g_pair
        logic signed [DATA_W:0] near_s, far_s;
        assign near_s = $signed({taps_i[k][DATA_W-1], taps_i[k]});
        assign far_s  = $signed({taps_i[TAPS-1-k][DATA_W-1], taps_i[TAPS-1-k]});
        if (MODE == fir_pkg::SYMMETRIC) begin : g_sym
            assign pair_o[k] = near_s + far_s;
        end else begin : g_anti
            assign pair_o[k] = near_s - far_s;
        end
    end
endmodule

// File: rtl/fir_mac.sv
// Multiplies each pre-added pair by its unique coefficient and sums the
// products at full precision. Coefficient k sits at COEFS[k*COEF_W +: COEF_W].
module fir_mac #(
    parameter int                     HALF   = 4,
    parameter int                     IN_W   = 13,
    parameter int                     COEF_W = 12,
    parameter logic [HALF*COEF_W-1:0] COEFS  = '0,
    parameter int                     OUT_W  = 27,
    localparam int                    PROD_W = IN_W + COEF_W
) (
    input  logic [HALF-1:0][IN_W-1:0] pair_i,
    output logic signed [OUT_W-1:0]   sum_o
);
    logic signed [PROD_W-1:0] prod_w [HALF];

    for (genvar k = 0; k < HALF; k++) begin : g_mul
        localparam logic signed [COEF_W-1:0] HK = COEFS[k*COEF_W +: COEF_W];
        assign prod_w[k] = $signed(pair_i[k]) * HK;
    end

    // Accumulate sign-extended products.
    always_comb begin
        sum_o = '0;
        for (int k = 0; k < HALF; k++) sum_o = sum_o + OUT_W'(prod_w[k]);
    end
endmodule

// File: rtl/lin_phase_fir.sv
// Even-length linear-phase FIR with mirrored pre-adders and TAPS/2
// multipliers. One output register; latency one cycle from in_valid.
// Assumes in_valid is low during reset. Result is full precision.
module lin_phase_fir #(
    parameter int                         TAPS   = 8,
    parameter int                         DATA_W = 12,
    parameter int                         COEF_W = 12,
    parameter fir_pkg::fir_sym_e          MODE   = fir_pkg::SYMMETRIC,
    parameter logic [TAPS/2*COEF_W-1:0]   COEFS  = {12'sd300, -12'sd40, 12'sd17, 12'sd5},
    localparam int                        HALF   = TAPS / 2,
    localparam int                        OUT_W  = fir_pkg::fir_out_width(DATA_W, COEF_W, TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    logic [TAPS-1:0][DATA_W-1:0] taps_w;
    logic [HALF-1:0][DATA_W:0]   pair_w;
    logic signed [OUT_W-1:0]     sum_w;

    fir_delay_line #(.TAPS(TAPS), .DATA_W(DATA_W)) u_line (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_data(in_data), .taps_o(taps_w)
    );

    fir_preadd #(.TAPS(TAPS), .DATA_W(DATA_W), .MODE(MODE)) u_pre (
        .taps_i(taps_w), .pair_o(pair_w)
    );

    fir_mac #(.HALF(HALF), .IN_W(DATA_W + 1), .COEF_W(COEF_W),
              .COEFS(COEFS), .OUT_W(OUT_W)) u_mac (
        .pair_i(pair_w), .sum_o(sum_w)
    );

    // Register the result and its strobe once per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= sum_w;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> (!out_valid && out_data == '0));

    assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data));
endmodule

// File: tb/lin_phase_fir_bench.sv
// Directed bench: symmetric and antisymmetric filters fed the same stream,
// compared with a direct-form convolution model kept in the bench.
module lin_phase_fir_bench;
    localparam int TAPS = 8;
    localparam int DW   = 12;
    localparam int CW   = 12;
    localparam int HALF = TAPS / 2;
    localparam int OW   = DW + 1 + CW + $clog2(HALF);
    localparam logic signed [CW-1:0] H0 = 12'sd5;
    localparam logic signed [CW-1:0] H1 = -12'sd40;
    localparam logic signed [CW-1:0] H2 = 12'sd300;
    localparam logic signed [CW-1:0] H3 = -12'sd2048;
    localparam logic [HALF*CW-1:0] CO = {H3, H2, H1, H0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic vs, va;
    logic signed [OW-1:0] ys, ya;

    int n_tests = 0;
    int n_fail  = 0;
    longint hist [TAPS];
    longint hfull [TAPS];
    longint exp_s, exp_a;

    always #2 clk = ~clk;

    lin_phase_fir #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW),
                    .MODE(fir_pkg::SYMMETRIC), .COEFS(CO)) u_lin_phase_fir (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(vs), .out_data(ys));

    lin_phase_fir #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW),
                    .MODE(fir_pkg::ANTISYMMETRIC), .COEFS(CO)) u_lin_phase_fir_anti (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(va), .out_data(ya));

    task automatic check(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FIR FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint conv(input bit anti);
        longint acc = 0;
        for (int i = 0; i < TAPS; i++) begin
            longint h = (i < HALF) ? hfull[i] : (anti ? -hfull[TAPS-1-i] : hfull[TAPS-1-i]);
            acc += h * hist[i];
        end
        return acc;
    endfunction

    // One clock: drive at falling edge, check after the rising edge.
    task automatic step(input longint x, input bit v, input string tag);
        @(negedge clk);
        in_valid = v;
        in_data  = DW'(x);
        if (v) begin
            for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = x;
            exp_s = conv(1'b0);
            exp_a = conv(1'b1);
        end
        @(posedge clk);
        #1;
        check({tag, " valid R2"}, longint'(vs), longint'(v));
        check({tag, " sym R3"}, longint'(ys), exp_s);
        check({tag, " anti R4"}, longint'(ya), exp_a);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        exp_s = 0; exp_a = 0;
    endtask

    task automatic test_reset();
        for (int i = 0; i < 5; i++) step(longint'(100 * i - 700), 1'b1, "prefill");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("reset valid R1", longint'(vs), 0);
        check("reset data R1", longint'(ys), 0);
        check("reset data anti R1", longint'(ya), 0);
        do_reset();
        step(0, 1'b1, "post-reset history R1");
    endtask

    // Impulse response exposes each coefficient slot (R8).
    task automatic test_impulse();
        do_reset();
        step(1, 1'b1, "impulse R8");
        for (int i = 1; i < TAPS + 2; i++) step(0, 1'b1, "impulse tail R8");
    endtask

    task automatic test_step();
        do_reset();
        for (int i = 0; i < TAPS + 3; i++) step(37, 1'b1, "step");
    endtask

    // Idle gaps must neither shift history nor change the output (R5, R6).
    task automatic test_gaps();
        do_reset();
        for (int i = 0; i < 12; i++) begin
            step(longint'(i * 113 - 600), 1'b1, "gapped R5");
            if (i % 3 == 0) begin
                step(999, 1'b0, "idle hold R6");
                step(-5, 1'b0, "idle hold R6");
            end
        end
    endtask

    task automatic test_random();
        do_reset();
        for (int i = 0; i < 200; i++) begin
            longint x = longint'($signed(DW'($urandom)));
            step(x, ($urandom % 5) != 0, "random");
        end
    endtask

    // Extreme samples: result must be exact at full width (R7).
    task automatic test_extremes();
        do_reset();
        for (int i = 0; i < TAPS + 1; i++) step(-2048, 1'b1, "all-min R7");
        for (int i = 0; i < TAPS + 2; i++) step((i % 2) ? 2047 : -2048, 1'b1, "alternating R7");
        for (int i = 0; i < TAPS + 1; i++) step(2047, 1'b1, "all-max R7");
    endtask

    initial begin
        hfull[0] = H0; hfull[1] = H1; hfull[2] = H2; hfull[3] = H3;
        for (int i = HALF; i < TAPS; i++) hfull[i] = 0;
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        exp_s = 0; exp_a = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("initial valid R1", longint'(vs), 0);
        check("initial data R1", longint'(ys), 0);
        test_reset();
        test_impulse();
        test_step();
        test_gaps();
        test_random();
        test_extremes();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FIR FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule